// File: doc/BRIEF.md
# Two-Wire Interface Data FIFO Port

This block is the data path between a 32-bit peripheral bus and the line-side shifter of a two-wire serial controller. It has a two-entry byte FIFO in each direction. Software loads the transmit FIFO with either a one-byte write or a packed two-byte write, and drains the receive FIFO one byte per read. A status register reports how full each FIFO is and whether a received byte was lost.

An access that cannot complete yet is not dropped. The block holds `bus_wait_o` high until the FIFO state allows the access, and the access then completes. The line side is modelled by two single-cycle strobes: one takes the head byte from the transmit FIFO, and the other pushes a received byte into the receive FIFO.

An access completes in any cycle where `bus_req_i` is high and `bus_wait_o` is low. Write data is taken in that cycle, and read data is valid on `bus_rdata_o` in that same cycle. The register index on `bus_addr_i` selects one of four registers:

| Index | Register |
|-------|----------|
| 0 | single-byte transmit |
| 1 | double-byte transmit |
| 2 | receive |
| 3 | status |

Top module: `twi_data_port`

## Requirements
- R1: A write to index 0 puts `bus_wdata_i[7:0]` at the tail of the transmit FIFO. It completes at once if the FIFO holds fewer than two bytes; otherwise `bus_wait_o` stays high until an entry is free.
- R2: A write to index 1 is allowed only when the transmit FIFO is empty; otherwise it waits until the FIFO is empty. When it completes, it loads `bus_wdata_i[7:0]` as the first byte to send and `bus_wdata_i[15:8]` as the second, which fills the FIFO.
- R3: Reads of index 0 and index 1 complete at once and return 0x00000000.
- R4: A read of index 2 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes exactly that one byte.
- R5: A read of index 2 while the receive FIFO is empty waits until at least one byte is present.
- R6: A read of index 3 returns the transmit fill level in bits 1:0 and the receive fill level in bits 3:2, each coded 0 = empty, 1 = one byte, 2 = full. Both levels reflect every completed access and every line strobe.
- R7: A `rx_push_i` strobe while the receive FIFO is full, with no receive read completing in the same cycle, discards the byte and sets the overflow flag, which is bit 4 of the status register. The flag stays set until a status read completes; that read still returns the flag as 1.
- R8: `tx_valid_o` is high exactly when the transmit FIFO is not empty, and `tx_byte_o` then shows its head byte. A `tx_pop_i` strobe removes the head byte; a strobe on an empty FIFO has no effect.
- R9: After reset both FIFOs are empty, the overflow flag is clear, and `bus_wait_o` is low.
- R10: `bus_wait_o` is high only while a request is present that cannot complete. Writes to indices 2 and 3 complete at once and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request; must be held until the access completes |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the completing cycle |
| bus_wait_o | output | 1 | Access stalled |
| tx_pop_i | input | 1 | Line side takes the transmit head byte |
| tx_byte_o | output | 8 | Transmit head byte |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| rx_push_i | input | 1 | Line side delivers a received byte |
| rx_byte_i | input | 8 | Received byte |

## Verification
The hardest situations to reach are a double-byte write stalled behind one leftover transmit byte, and a receive read that stalls on an empty FIFO while a line push arrives in the same cycle. Both depend on how bus traffic and line strobes happen to line up. The bench holds each pending access across cycles while drawing line strobes at random from a fixed seed, so the FIFOs pass through every level under both stalled and free-running access patterns. A directed overflow sequence and a directed double-byte stall that drains one pop at a time then pin down the sticky flag and the exact release cycle.

// File: rtl/twi_fifo_pkg.sv
package twi_fifo_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_TX8  = 2'd0,
    REG_TX16 = 2'd1,
    REG_RX8  = 2'd2,
    REG_STAT = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/twi_byte_fifo.sv
module twi_byte_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       push_cnt_i,   // 0, 1 or 2 entries; caller guarantees space
  input  logic [W-1:0]     din0_i,
  input  logic [W-1:0]     din1_i,
  input  logic             pop_i,        // caller guarantees not empty
  output logic [W-1:0]     dout_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, wr_p1, wr_p2;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_p1 = inc(wr_q);
  assign wr_p2 = inc(wr_p1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      level_q <= '0;
    end else begin
      if (pop_i) rd_q <= inc(rd_q);
      case (push_cnt_i)
        2'd1:    wr_q <= wr_p1;
        2'd2:    wr_q <= wr_p2;
        default: wr_q <= wr_q;
      endcase
      level_q <= level_q + LVL_W'(push_cnt_i) - LVL_W'(pop_i);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_cnt_i != 2'd0 && wr_q == PTR_W'(i))      mem_q[i] <= din0_i;
      else if (push_cnt_i == 2'd2 && wr_p1 == PTR_W'(i)) mem_q[i] <= din1_i;
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign level_o = level_q;

  a_r6_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_q != '0);
  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(level_q) + 32'(push_cnt_i)) <= (32'(DEPTH) + 32'(pop_i)));
endmodule

// File: rtl/twi_bus_ctrl.sv
module twi_bus_ctrl
  import twi_fifo_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 2,
  parameter int unsigned RX_DEPTH = 2,
  localparam int unsigned TX_LVL_W = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [TX_LVL_W-1:0] tx_level_i,
  input  logic [RX_LVL_W-1:0] rx_level_i,
  output logic                wait_o,
  output logic [1:0]          tx_push_cnt_o,
  output logic                rx_pop_o,
  output logic                stat_rd_o
);
  logic ready, done;
  reg_idx_e idx;

  assign idx = reg_idx_e'(addr_i);

  always_comb begin
    ready = 1'b1;
    if (we_i) begin
      case (idx)
        REG_TX8:  ready = tx_level_i < TX_LVL_W'(TX_DEPTH);
        REG_TX16: ready = tx_level_i == '0;
        default:  ready = 1'b1;
      endcase
    end else if (idx == REG_RX8) begin
      ready = rx_level_i != '0;
    end
  end

  assign done   = req_i && ready;
  assign wait_o = req_i && !ready;

  always_comb begin
    tx_push_cnt_o = 2'd0;
    if (done && we_i && idx == REG_TX8)  tx_push_cnt_o = 2'd1;
    if (done && we_i && idx == REG_TX16) tx_push_cnt_o = 2'd2;
  end

  assign rx_pop_o  = done && !we_i && idx == REG_RX8;
  assign stat_rd_o = done && !we_i && idx == REG_STAT;

  a_r2_tx16_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == REG_TX16 && tx_level_i != '0) |-> wait_o);
  a_r5_rx_empty_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx == REG_RX8 && rx_level_i == '0) |-> wait_o);
  a_r1_tx8_full_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == REG_TX8 && tx_level_i == TX_LVL_W'(TX_DEPTH)) |-> wait_o);
  a_r10_wait_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> req_i);
  a_r10_held_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> (req_i && $stable(addr_i) && $stable(we_i)));
endmodule

// File: rtl/twi_data_port.sv
module twi_data_port
  import twi_fifo_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 2,
  parameter int unsigned RX_DEPTH = 2,
  localparam int unsigned TX_LVL_W = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LVL_W = $clog2(RX_DEPTH + 1),
  localparam int unsigned STAT_W   = TX_LVL_W + RX_LVL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_wait_o,
  input  logic              tx_pop_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_byte_i
);
  logic [TX_LVL_W-1:0] tx_level;
  logic [RX_LVL_W-1:0] rx_level;
  logic [1:0]          tx_push_cnt;
  logic                rx_pop, stat_rd, tx_pop, rx_accept, rx_drop;
  logic                ovf_q;
  logic [BYTE_W-1:0]   rx_head;
  logic [STAT_W-1:0]   stat_word;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:2*BYTE_W];

  twi_bus_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (bus_req_i),
    .we_i          (bus_we_i),
    .addr_i        (bus_addr_i),
    .tx_level_i    (tx_level),
    .rx_level_i    (rx_level),
    .wait_o        (bus_wait_o),
    .tx_push_cnt_o (tx_push_cnt),
    .rx_pop_o      (rx_pop),
    .stat_rd_o     (stat_rd)
  );

  assign tx_pop = tx_pop_i && tx_level != '0;

  twi_byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_tx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_cnt_i (tx_push_cnt),
    .din0_i     (bus_wdata_i[BYTE_W-1:0]),
    .din1_i     (bus_wdata_i[2*BYTE_W-1:BYTE_W]),
    .pop_i      (tx_pop),
    .dout_o     (tx_byte_o),
    .level_o    (tx_level)
  );

  // a same-cycle read frees the slot the push needs
  assign rx_accept = rx_push_i && (rx_level != RX_LVL_W'(RX_DEPTH) || rx_pop);
  assign rx_drop   = rx_push_i && !rx_accept;

  twi_byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_cnt_i ({1'b0, rx_accept}),
    .din0_i     (rx_byte_i),
    .din1_i     (rx_byte_i),
    .pop_i      (rx_pop),
    .dout_o     (rx_head),
    .level_o    (rx_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q && !stat_rd) || rx_drop;
  end

  assign tx_valid_o = tx_level != '0;
  assign stat_word  = {ovf_q, rx_level, tx_level};

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i && !bus_wait_o) begin
      case (reg_idx_e'(bus_addr_i))
        REG_RX8:  bus_rdata_o = DATA_W'(rx_head);
        REG_STAT: bus_rdata_o = DATA_W'(stat_word);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !stat_rd) |=> ovf_q);
  a_r7_drop_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> ovf_q);
  a_r8_valid_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_pop && tx_push_cnt == 2'd0) |=> (tx_valid_o && $stable(tx_byte_o)));
  a_r3_tx_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i[1] == 1'b0) |-> bus_rdata_o == '0);
endmodule

// File: tb/tb_twi_data_port.sv
module tb_twi_data_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wt;
  logic        pop = 1'b0, push = 1'b0;
  logic [7:0]  pbyte = '0;
  logic [7:0]  txb;
  logic        txv;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit ovf = 1'b0;

  always #2.5 clk = ~clk;

  twi_data_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_wait_o(wt), .tx_pop_i(pop),
    .tx_byte_o(txb), .tx_valid_o(txv), .rx_push_i(push), .rx_byte_i(pbyte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 tx8 wr, 1 tx16 wr, 2 rx rd, 3 stat rd, 4 tx8 rd, 5 tx16 rd, 6 rx wr, 7 stat wr
  function automatic bit op_we(input int op);
    return op inside {0, 1, 6, 7};
  endfunction
  function automatic logic [1:0] op_addr(input int op);
    case (op)
      0, 4: return 2'd0;
      1, 5: return 2'd1;
      2, 6: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
  function automatic bit model_ready(input int op);
    case (op)
      0: return tx_q.size() < 2;
      1: return tx_q.size() == 0;
      2: return rx_q.size() > 0;
      default: return 1'b1;
    endcase
  endfunction
  function automatic logic [31:0] model_rdata(input int op);
    case (op)
      2: return {24'h0, rx_q[0]};
      3: return {27'h0, ovf, 2'(rx_q.size()), 2'(tx_q.size())};
      default: return 32'h0;
    endcase
  endfunction

  // one clock cycle: drive, check before the edge, update the model at the edge
  task automatic tick(input bit r, input int op, input logic [31:0] wd,
                      input bit p, input bit pu, input logic [7:0] pb, output bit done);
    bit rdy, rd_now;
    @(negedge clk);
    req = r; we = op_we(op); addr = op_addr(op); wdata = wd;
    pop = p; push = pu; pbyte = pb;
    #1;
    rdy = model_ready(op);
    done = r && rdy;
    case (op)
      0: check("R1 wait", {31'h0, wt}, {31'h0, r && !rdy});
      1: check("R2 wait", {31'h0, wt}, {31'h0, r && !rdy});
      2: check("R5 wait", {31'h0, wt}, {31'h0, r && !rdy});
      default: check("R10 wait", {31'h0, wt}, 32'h0);
    endcase
    if (done && !op_we(op)) begin
      case (op)
        2: check("R4 rx data", rdata, model_rdata(op));
        3: check("R6 R7 status", rdata, model_rdata(op));
        default: check("R3 tx read", rdata, 32'h0);
      endcase
    end
    check("R8 valid", {31'h0, txv}, {31'h0, tx_q.size() > 0});
    if (tx_q.size() > 0) check("R8 head", {24'h0, txb}, {24'h0, tx_q[0]});
    @(posedge clk);
    if (p && tx_q.size() > 0) void'(tx_q.pop_front());
    rd_now = done && op == 2;
    if (done && op == 0) tx_q.push_back(wd[7:0]);
    if (done && op == 1) begin tx_q.push_back(wd[7:0]); tx_q.push_back(wd[15:8]); end
    if (rd_now) void'(rx_q.pop_front());
    if (done && op == 3) ovf = 1'b0;
    if (pu) begin
      if (rx_q.size() < 2) rx_q.push_back(pb);
      else ovf = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit d;
    bit cur_req = 1'b0;
    int cur_op = 0;
    logic [31:0] cur_wd = '0;
    int guard;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 wait", {31'h0, wt}, 32'h0);
    check("R9 valid", {31'h0, txv}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    tick(1, 3, 0, 0, 0, 0, d);  // status all zero

    // R7: overflow, sticky, cleared by status read
    tick(0, 3, 0, 0, 1, 8'hA1, d);
    tick(0, 3, 0, 0, 1, 8'hA2, d);
    tick(0, 3, 0, 0, 1, 8'hA3, d);  // dropped
    tick(0, 3, 0, 0, 0, 0, d);
    tick(1, 3, 0, 0, 0, 0, d);      // reads ovf=1, rx=2
    tick(1, 3, 0, 0, 0, 0, d);      // ovf cleared
    // R4/R7: read while full with same-cycle push keeps the push
    tick(1, 2, 0, 0, 1, 8'hA4, d);
    tick(1, 3, 0, 0, 0, 0, d);
    tick(1, 2, 0, 0, 0, 0, d);
    tick(1, 2, 0, 0, 0, 0, d);
    // R5: read on empty waits, then push releases it
    tick(1, 2, 0, 0, 0, 0, d);
    tick(1, 2, 0, 0, 1, 8'h5C, d);
    tick(1, 2, 0, 0, 0, 0, d);
    check("R5 released", {31'h0, d}, 32'h1);

    // R2: double write stalls behind one leftover byte
    tick(1, 0, 32'h0000_0011, 0, 0, 0, d);
    tick(1, 1, 32'h0000_3322, 0, 0, 0, d);
    tick(1, 1, 32'h0000_3322, 0, 0, 0, d);
    check("R2 stalled", {31'h0, d}, 32'h0);
    tick(1, 1, 32'h0000_3322, 1, 0, 0, d);
    tick(1, 1, 32'h0000_3322, 0, 0, 0, d);
    check("R2 completes when empty", {31'h0, d}, 32'h1);
    tick(1, 0, 32'h0000_0044, 0, 0, 0, d);  // R1: full, stalls
    check("R1 stalled", {31'h0, d}, 32'h0);
    tick(1, 0, 32'h0000_0044, 1, 0, 0, d);
    tick(1, 0, 32'h0000_0044, 1, 0, 0, d);
    tick(0, 0, 0, 1, 0, 0, d);
    tick(0, 0, 0, 1, 0, 0, d);              // R8: pop on empty
    tick(1, 6, 32'hFF, 0, 0, 0, d);         // R10: ignored writes
    tick(1, 7, 32'hFF, 0, 0, 0, d);
    tick(1, 3, 0, 0, 0, 0, d);

    for (int i = 0; i < 4000; i++) begin
      if (!cur_req && ($urandom % 3 == 0)) begin
        cur_req = 1'b1;
        cur_op = $urandom % 8;
        cur_wd = $urandom;
      end
      tick(cur_req, cur_op, cur_wd, ($urandom % 10) < 3, ($urandom % 10) < 3, 8'($urandom), d);
      if (d) cur_req = 1'b0;
    end
    guard = 0;
    while (cur_req && guard < 20) begin
      tick(cur_req, cur_op, cur_wd, 1, 1, 8'($urandom), d);
      if (d) cur_req = 1'b0;
      guard++;
    end
    tick(0, 0, 0, 0, 0, 0, d);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule